// File: doc/BRIEF.md
# Transfer Descriptor Schedule Walker

The block walks a table of transfer descriptors held in an on-chip descriptor memory and decides, slot by slot, which descriptors need a bus transaction. There are three descriptor lists of 32 slots each, walked in a fixed order on every frame tick while the schedule is enabled: isochronous (list 0), interrupt (list 1), asynchronous (list 2). For each slot the walker reads two descriptor words over a one-cycle-latency read port, issues a transaction request when the descriptor is live, and waits for an acknowledge before moving on.

Three controls shape a list's walk. A per-slot skip bitmap hides a slot without reading it. A per-list last-slot marker cuts the walk short. A forward-only jump index inside each descriptor lets the walker pass over unused slots. Executing the transaction and writing back status are handled elsewhere. The walker only reports which slot of which list needs service.

Top module: `td_sched_walker`

## Requirements
- R1: After reset, state_o is 0 (idle), list_o is 0, and req_o and rd_en_o are low.
- R2: A frame walk starts only on a clock where sof_i and sched_en_i are both high. Without that, the block stays idle and issues no request.
- R3: A frame walks list 0, then list 1, then list 2, and then returns to idle.
- R4: For each unskipped slot, the block reads word 0 and then word 4 at rd_addr_o = {list[1:0], slot[4:0], word[2:0]}. Data arrives on rd_data_i one clock after rd_en_o. rd_data_i carries the low 5 bits of the word. Word 0 bit 0 is the active flag and bit 1 is the done flag.
- R5: A request (req_o with req_list_o and req_slot_o) is raised only for an active, not-done descriptor. It holds steady until ack_i is sampled high.
- R6: Within a list, slots are visited in ascending order. When a fetched descriptor's jump index (word 4 bits 4:0) is above the current slot, that slot is visited next.
- R7: A jump index of zero, or one not above the current slot, gives the next sequential slot.
- R8: When skip_map_i bit list*32+slot is set, the slot is neither read nor requested, and the walk goes to the next sequential slot.
- R9: When last_en_i[list] is set, the list ends after slot last_slot_i[list*5 +: 5] is handled. A jump past that slot also ends the list.
- R10: A list ends after slot 31 when no marker ends it earlier.
- R11: state_o encodes idle=0, fetch=1, evaluate=2, request=3, next-list=4. list_o gives the list being walked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sched_en_i | input | 1 | Schedule enable, sampled at the frame tick |
| sof_i | input | 1 | Frame tick |
| skip_map_i | input | 96 | Skip bits, bit list*32+slot |
| last_en_i | input | 3 | Last-slot marker enable per list |
| last_slot_i | input | 15 | Last-slot marker per list, 5 bits each |
| rd_en_o | output | 1 | Descriptor read strobe |
| rd_addr_o | output | 10 | Descriptor word address {list, slot, word} |
| rd_data_i | input | 5 | Low bits of the addressed word, one clock after the strobe |
| req_o | output | 1 | Transaction request |
| ack_i | input | 1 | Transaction acknowledge |
| req_slot_o | output | 5 | Slot of the requested descriptor |
| req_list_o | output | 2 | List of the requested descriptor |
| state_o | output | 3 | Walker state |
| list_o | output | 2 | Current list |

## Verification
The assertions assume that skip_map_i, last_en_i and last_slot_i stay constant while a frame walk is in progress. The bench changes them only while state_o reads idle. They also assume that the memory answers with one clock of latency, which the bench's memory model provides. The bench raises ack_i only while req_o is high and holds it for a single clock. It waits a random zero to two clocks before acknowledging, so the hold-until-acknowledge check sees both stalled and immediate handshakes.

// File: rtl/tdw_pkg.sv
package tdw_pkg;
  localparam int SLOT_W    = 5;
  localparam int NUM_SLOTS = 1 << SLOT_W;
  localparam int LIST_N    = 3;
  localparam int LIST_W    = 2;
  localparam int WORD_W    = 3;
  localparam int ADDR_W    = LIST_W + SLOT_W + WORD_W;

  typedef enum logic [LIST_W-1:0] {
    LST_ISO = 2'd0,
    LST_INT = 2'd1,
    LST_ASY = 2'd2
  } list_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_EVAL  = 3'd2,
    ST_REQ   = 3'd3,
    ST_NEXTL = 3'd4
  } state_e;
endpackage

// File: rtl/tdw_list_cfg.sv
module tdw_list_cfg import tdw_pkg::*; (
  input  logic [LIST_W-1:0]           list_i,
  input  logic [SLOT_W-1:0]           slot_i,
  input  logic [LIST_N*NUM_SLOTS-1:0] skip_map_i,
  input  logic [LIST_N-1:0]           last_en_i,
  input  logic [LIST_N*SLOT_W-1:0]    last_slot_i,
  output logic                        skip_o,
  output logic                        lst_en_o,
  output logic [SLOT_W-1:0]           lst_slot_o
);
  logic [NUM_SLOTS-1:0] skip_a [LIST_N];
  logic [SLOT_W-1:0]    last_a [LIST_N];

  for (genvar g = 0; g < LIST_N; g++) begin : g_unpack
    assign skip_a[g] = skip_map_i[g*NUM_SLOTS +: NUM_SLOTS];
    assign last_a[g] = last_slot_i[g*SLOT_W +: SLOT_W];
  end

  always_comb begin
    skip_o     = 1'b0;
    lst_en_o   = 1'b0;
    lst_slot_o = '0;
    for (int k = 0; k < LIST_N; k++) begin
      if (list_i == LIST_W'(k)) begin
        skip_o     = skip_a[k][slot_i];
        lst_en_o   = last_en_i[k];
        lst_slot_o = last_a[k];
      end
    end
  end
endmodule

// File: rtl/tdw_slot_step.sv
module tdw_slot_step import tdw_pkg::*; (
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [SLOT_W-1:0] ptr_i,
  input  logic              use_ptr_i,
  input  logic              lst_en_i,
  input  logic [SLOT_W-1:0] lst_slot_i,
  output logic [SLOT_W-1:0] next_slot_o,
  output logic              list_end_o
);
  localparam logic [SLOT_W-1:0] MAX_SLOT = SLOT_W'(NUM_SLOTS - 1);

  logic          jump;
  logic [SLOT_W:0] cand;

  // forward-only jump; zero means none
  assign jump        = use_ptr_i && (ptr_i != '0) && (ptr_i > slot_i);
  assign cand        = jump ? {1'b0, ptr_i} : ({1'b0, slot_i} + 1'b1);
  assign next_slot_o = cand[SLOT_W-1:0];
  assign list_end_o  = (slot_i == MAX_SLOT) || (lst_en_i && (cand > {1'b0, lst_slot_i}));
endmodule

// File: rtl/td_sched_walker.sv
module td_sched_walker import tdw_pkg::*; #(
  parameter int ACT_BIT   = 0,
  parameter int DONE_BIT  = 1,
  parameter int FLAG_WORD = 0,
  parameter int PTR_WORD  = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        sched_en_i,
  input  logic                        sof_i,
  input  logic [LIST_N*NUM_SLOTS-1:0] skip_map_i,
  input  logic [LIST_N-1:0]           last_en_i,
  input  logic [LIST_N*SLOT_W-1:0]    last_slot_i,
  output logic                        rd_en_o,
  output logic [ADDR_W-1:0]           rd_addr_o,
  input  logic [SLOT_W-1:0]           rd_data_i,
  output logic                        req_o,
  input  logic                        ack_i,
  output logic [SLOT_W-1:0]           req_slot_o,
  output logic [LIST_W-1:0]           req_list_o,
  output logic [2:0]                  state_o,
  output logic [LIST_W-1:0]           list_o
);
  state_e            state_q;
  list_e             list_q;
  logic [SLOT_W-1:0] slot_q, ptr_q, next_slot, lst_slot;
  logic [1:0]        fcnt_q;
  logic              act_q, done_q;
  logic              skip_bit, lst_en, list_end, use_ptr;

  tdw_list_cfg u_cfg (
    .list_i      (list_q),
    .slot_i      (slot_q),
    .skip_map_i  (skip_map_i),
    .last_en_i   (last_en_i),
    .last_slot_i (last_slot_i),
    .skip_o      (skip_bit),
    .lst_en_o    (lst_en),
    .lst_slot_o  (lst_slot)
  );

  assign use_ptr = (state_q == ST_EVAL) || (state_q == ST_REQ);

  tdw_slot_step u_step (
    .slot_i      (slot_q),
    .ptr_i       (ptr_q),
    .use_ptr_i   (use_ptr),
    .lst_en_i    (lst_en),
    .lst_slot_i  (lst_slot),
    .next_slot_o (next_slot),
    .list_end_o  (list_end)
  );

  always_comb begin
    rd_en_o   = (state_q == ST_FETCH) && (((fcnt_q == 2'd0) && !skip_bit) || (fcnt_q == 2'd1));
    rd_addr_o = {list_q, slot_q, (fcnt_q == 2'd0) ? WORD_W'(FLAG_WORD) : WORD_W'(PTR_WORD)};
  end

  assign req_o      = (state_q == ST_REQ);
  assign req_slot_o = slot_q;
  assign req_list_o = list_q;
  assign state_o    = state_q;
  assign list_o     = list_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      list_q  <= LST_ISO;
      slot_q  <= '0;
      ptr_q   <= '0;
      fcnt_q  <= '0;
      act_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (sof_i && sched_en_i) begin
          state_q <= ST_FETCH;
          list_q  <= LST_ISO;
          slot_q  <= '0;
          fcnt_q  <= '0;
        end
        ST_FETCH: begin
          if (fcnt_q == 2'd0) begin
            if (skip_bit) begin
              if (list_end) state_q <= ST_NEXTL;
              else          slot_q  <= next_slot;
            end else fcnt_q <= 2'd1;
          end else if (fcnt_q == 2'd1) begin
            act_q  <= rd_data_i[ACT_BIT];
            done_q <= rd_data_i[DONE_BIT];
            fcnt_q <= 2'd2;
          end else begin
            ptr_q   <= rd_data_i;
            fcnt_q  <= 2'd0;
            state_q <= ST_EVAL;
          end
        end
        ST_EVAL, ST_REQ: begin
          if ((state_q == ST_EVAL && act_q && !done_q)) begin
            state_q <= ST_REQ;
          end else if (state_q == ST_EVAL || ack_i) begin
            if (list_end) state_q <= ST_NEXTL;
            else begin
              slot_q  <= next_slot;
              fcnt_q  <= 2'd0;
              state_q <= ST_FETCH;
            end
          end
        end
        ST_NEXTL: begin
          if (list_q == LST_ASY) state_q <= ST_IDLE;
          else begin
            list_q  <= list_e'(list_q + 2'd1);
            slot_q  <= '0;
            fcnt_q  <= '0;
            state_q <= ST_FETCH;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE |-> !req_o && !rd_en_o); // R2
  AST_LIST_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    list_q != $past(list_q) |-> (list_q == LIST_W'($past(list_q) + 2'd1)) || (list_q == LST_ISO)); // R3
  AST_REQ_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> act_q && !done_q); // R5
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(req_slot_o) && $stable(req_list_o)); // R5
  AST_FWD_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (list_q == $past(list_q)) && (slot_q != $past(slot_q)) && (state_q != ST_FETCH || $past(state_q) != ST_NEXTL)
      |-> slot_q > $past(slot_q)); // R6
  AST_SKIP_NO_EVAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_EVAL |-> !skip_bit); // R8
  AST_NOT_PAST_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EVAL) && lst_en |-> slot_q <= lst_slot); // R9
endmodule

// File: tb/td_sched_walker_test.sv
`timescale 1ns/1ps
module td_sched_walker_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sched_en_i = 1'b0;
  logic        sof_i = 1'b0;
  logic [95:0] skip_map_i = '0;
  logic [2:0]  last_en_i = '0;
  logic [14:0] last_slot_i = '0;
  logic        rd_en_o;
  logic [9:0]  rd_addr_o;
  logic [4:0]  rd_data_i = '0;
  logic        req_o;
  logic        ack_i = 1'b0;
  logic [4:0]  req_slot_o;
  logic [1:0]  req_list_o;
  logic [2:0]  state_o;
  logic [1:0]  list_o;

  td_sched_walker uut (.*);

  always #4 clk_i = ~clk_i;

  logic       m_act  [3][32];
  logic       m_done [3][32];
  logic [4:0] m_ptr  [3][32];

  int n_chk = 0, n_fail = 0;
  int rd_cnt = 0;
  int got_n = 0, exp_n = 0;
  logic [6:0] got_q [0:127];
  logic [6:0] exp_q [0:127];
  int hold = 0;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    if (rd_en_o) begin
      rd_cnt <= rd_cnt + 1;
      if (rd_addr_o[2:0] == 3'd0)
        rd_data_i <= {3'b101, m_done[rd_addr_o[9:8]][rd_addr_o[7:3]], m_act[rd_addr_o[9:8]][rd_addr_o[7:3]]};
      else if (rd_addr_o[2:0] == 3'd4)
        rd_data_i <= m_ptr[rd_addr_o[9:8]][rd_addr_o[7:3]];
      else
        rd_data_i <= 5'h1f;
    end
  end

  // acknowledge with random delay; log each request once
  always @(negedge clk_i) begin
    if (ack_i) ack_i = 1'b0;
    else if (req_o) begin
      if (hold == 0) begin
        if (state_o != 3'd3 || list_o != req_list_o)
          check(1'b0, "R11", int'(state_o), 3);
        if (got_n < 128) got_q[got_n] = {req_list_o, req_slot_o};
        got_n++;
        ack_i = 1'b1;
        hold = $urandom % 3;
      end else hold--;
    end
  end

  function automatic void build_expected();
    exp_n = 0;
    for (int l = 0; l < 3; l++) begin
      int s = 0;
      int nx;
      bit fin = 0;
      while (!fin) begin
        if (skip_map_i[l*32+s]) nx = s + 1;
        else begin
          if (m_act[l][s] && !m_done[l][s]) begin
            exp_q[exp_n] = {2'(l), 5'(s)};
            exp_n++;
          end
          nx = (int'(m_ptr[l][s]) > s) ? int'(m_ptr[l][s]) : s + 1;
        end
        if (s == 31 || (last_en_i[l] && nx > int'(last_slot_i[l*5 +: 5]))) fin = 1;
        else s = nx;
      end
    end
  endfunction

  function automatic int exp_reads();
    int r = 0;
    return r;
  endfunction

  task automatic run_frame(input string tag);
    int guard = 0;
    int bad = -1;
    build_expected();
    got_n = 0;
    @(negedge clk_i);
    sched_en_i = 1'b1;
    sof_i = 1'b1;
    @(negedge clk_i);
    sof_i = 1'b0;
    while (state_o != 3'd0 && guard < 20000) begin
      @(negedge clk_i);
      guard++;
    end
    check(state_o == 3'd0, {tag, " R3 walk returns idle"}, int'(state_o), 0);
    check(got_n == exp_n, {tag, " request count"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++)
      if (bad < 0 && got_q[i] != exp_q[i]) bad = i;
    check(bad < 0, {tag, " R6 request order"}, (bad < 0) ? 0 : int'(got_q[bad]),
          (bad < 0) ? 0 : int'(exp_q[bad]));
  endtask

  task automatic clear_mem(input bit act);
    for (int l = 0; l < 3; l++)
      for (int s = 0; s < 32; s++) begin
        m_act[l][s] = act; m_done[l][s] = 1'b0; m_ptr[l][s] = 5'd0;
      end
    skip_map_i = '0; last_en_i = '0; last_slot_i = '0;
  endtask

  task automatic rand_mem();
    for (int l = 0; l < 3; l++)
      for (int s = 0; s < 32; s++) begin
        m_act[l][s]  = ($urandom % 2) == 0;
        m_done[l][s] = ($urandom % 4) == 0;
        m_ptr[l][s]  = (($urandom % 3) == 0) ? 5'($urandom) : 5'd0;
        skip_map_i[l*32+s] = ($urandom % 5) == 0;
      end
    last_en_i = 3'($urandom);
    last_slot_i = 15'($urandom);
  endtask

  initial begin
    int wd = 0;
    while (wd < 190000) begin @(posedge clk_i); wd++; end
    check(1'b0, "watchdog", wd, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    clear_mem(1'b0);
    repeat (3) @(negedge clk_i);
    check(state_o == 3'd0 && !req_o && !rd_en_o && list_o == 2'd0, "R1 reset state", int'(state_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2: tick with schedule disabled, and enable without tick
    clear_mem(1'b1);
    got_n = 0;
    sched_en_i = 1'b0; sof_i = 1'b1;
    @(negedge clk_i); sof_i = 1'b0; sched_en_i = 1'b1;
    repeat (20) @(negedge clk_i);
    check(state_o == 3'd0 && got_n == 0, "R2 no walk without tick and enable", got_n, 0);

    // R7 R10 R4: all live, no pointers
    clear_mem(1'b1);
    rd_cnt = 0;
    run_frame("R10 full walk");
    check(rd_cnt == 192, "R4 two reads per slot", rd_cnt, 192);

    // R8: all skipped, nothing read
    clear_mem(1'b1);
    skip_map_i = '1;
    rd_cnt = 0;
    run_frame("R8 all skipped");
    check(rd_cnt == 0, "R8 skipped slots not read", rd_cnt, 0);

    // R7: pointers equal or behind the slot
    clear_mem(1'b1);
    for (int s = 0; s < 32; s++) begin
      m_ptr[0][s] = 5'(s); m_ptr[1][s] = 5'(s / 2); m_ptr[2][s] = 5'd0;
    end
    run_frame("R7 backward pointers");

    // R6: forward jump chain
    clear_mem(1'b1);
    m_ptr[0][0] = 5'd5; m_ptr[0][5] = 5'd20; m_ptr[1][3] = 5'd31;
    run_frame("R6 jump chain");

    // R8: pointer in a skipped slot is ignored
    clear_mem(1'b1);
    m_ptr[2][0] = 5'd30; skip_map_i[64] = 1'b1; m_ptr[2][1] = 5'd4;
    run_frame("R8 skipped pointer");

    // R9: marker, and jump past it
    clear_mem(1'b1);
    last_en_i = 3'b011; last_slot_i = {5'd0, 5'd6, 5'd10};
    m_ptr[0][3] = 5'd15;
    skip_map_i[32+6] = 1'b1;
    run_frame("R9 last marker");

    // R5: inactive and done descriptors
    clear_mem(1'b1);
    for (int s = 0; s < 32; s += 3) m_done[1][s] = 1'b1;
    for (int s = 0; s < 32; s += 4) m_act[2][s] = 1'b0;
    run_frame("R5 live only");

    for (int i = 0; i < 15; i++) begin
      rand_mem();
      run_frame("R3 random frame");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule